// File: doc/BRIEF.md
# SD Card Data FIFO with Direction-Aware Threshold Flag

This block is the word buffer between the host-facing 32-bit data register and the SD card data shifter. It holds 16 words of 32 bits and runs on one clock. The transfer direction decides which side fills it and which side drains it. In a card-to-host read, the shifter pushes words and the host pops them through data-register reads. In a host-to-card write, the host pushes words through data-register writes and the shifter pops them.

A single status flag tells software when to service the buffer. Its meaning depends on the direction. During reads it says that at least the programmed read threshold of words is waiting. During writes it says that at least the programmed write threshold of free slots exists. A debug word reports the live fill level next to both 5-bit thresholds.

Sticky status bits record a FIFO error and a block completion. The error bit covers a push into a full buffer and a pop from an empty one. The block bit is set after a programmed number of shifter-side words. Each sticky bit can drive the interrupt output through its own enable.

Top module: `sd_data_fifo`

## Requirements
- R1: The buffer holds 16 words of 32 bits and returns them in arrival order. When `dir_rd`=1, words enter from the shifter push port and leave through host reads. When `dir_rd`=0, words enter through host writes and leave through the shifter pop port. Popped data appears combinationally on `host_rdata` or `shf_pop_data` in the cycle of the pop.
- R2: `dbg_word` carries the fill level in bits 8:4, the write threshold in bits 13:9 and the read threshold in bits 18:14. All its other bits are 0. The level changes on the clock edge that ends the accepting cycle.
- R3: When `dir_rd`=1, status bit 0 of `stat_word` is 1 exactly when the fill level is at least `cfg_rd_thr`.
- R4: When `dir_rd`=0, status bit 0 is 1 exactly when 16 minus the fill level is at least `cfg_wr_thr`.
- R5: `irq` is the OR of two terms. The first is status bit 0 AND `cfg_data_irq_en`. The second is status bit 9 AND `cfg_blk_irq_en`.
- R6: A push that finds the buffer full at the start of the cycle is dropped, even when a pop happens in the same cycle. The contents stay unchanged, and the sticky error bit 3 of `stat_word` is set on the next edge.
- R7: A pop that finds the buffer empty at the start of the cycle returns 0 and sets status bit 3 on the next edge.
- R8: Each accepted shifter-side word counts toward the block length `cfg_blk_words`. The count uses shifter pushes in read direction and shifter pops in write direction. The word that completes a block sets sticky status bit 9 on the next edge and restarts the count. A block length of 0 never sets it.
- R9: `clr_err` clears bit 3 and `clr_blk` clears bit 9 on the next edge. A new error or block completion in the same cycle wins over the clear.
- R10: Operations on the inactive side have no effect on level, data or status. In read direction these are host writes and shifter pops. In write direction these are shifter pushes and host reads. Their data outputs stay 0.
- R11: `xfer_start` empties the buffer and restarts the block count on the next edge. Any push or pop in that cycle is discarded without error. The sticky bits keep their values.
- R12: After reset the level is 0 and bits 3 and 9 are 0. All other status bits besides 0, 3 and 9 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Flush buffer and block count for a new transfer |
| dir_rd | input | 1 | 1 = card-to-host read, 0 = host-to-card write |
| host_wr_en | input | 1 | Host data-register write strobe |
| host_wdata | input | 32 | Host write data |
| host_rd_en | input | 1 | Host data-register read strobe |
| host_rdata | output | 32 | Host read data, 0 unless a read pop succeeds |
| shf_push | input | 1 | Shifter word push strobe |
| shf_push_data | input | 32 | Shifter pushed word |
| shf_pop | input | 1 | Shifter word pop strobe |
| shf_pop_data | output | 32 | Word given to shifter, 0 unless a write pop succeeds |
| cfg_rd_thr | input | 5 | Read threshold in words |
| cfg_wr_thr | input | 5 | Write threshold in free slots |
| cfg_blk_words | input | 8 | Block length in words, 0 disables |
| cfg_data_irq_en | input | 1 | Data flag interrupt enable |
| cfg_blk_irq_en | input | 1 | Block completion interrupt enable |
| clr_err | input | 1 | Clear sticky error bit |
| clr_blk | input | 1 | Clear sticky block bit |
| dbg_word | output | 32 | Level and thresholds |
| stat_word | output | 32 | Bit 0 data flag, bit 3 error, bit 9 block done |
| irq | output | 1 | Interrupt request |

## Verification
The bench attacks the full boundary with a push and a pop in the same cycle. A design that judged fullness after the pop would accept the word and leave the error bit clear. It exercises the flag at exactly the threshold in both directions. An off-by-one comparison, or a write flag computed from the level instead of the free space, shows up there as a flag one word early or late. It also drives operations on the wrong side, a flush with traffic in the same cycle, and a clear colliding with a fresh error. A design that leaked the wrong side's strobes would move the level. One that let the clear win would lose an error. A behavioural queue model runs alongside for a long mixed random stretch and catches any ordering or wrap fault.

// File: rtl/sd_fifo_pkg.sv
package sd_fifo_pkg;

  localparam int FLD_W       = 5;
  localparam int DBG_LVL_LSB = 4;
  localparam int DBG_WTH_LSB = 9;
  localparam int DBG_RTH_LSB = 14;
  localparam int ST_DATA_BIT = 0;
  localparam int ST_ERR_BIT  = 3;
  localparam int ST_BLK_BIT  = 9;

  // Free slots in a buffer of the given depth.
  function automatic logic [5:0] free_slots(input logic [5:0] lvl, input logic [5:0] depth);
    return depth - lvl;
  endfunction

  // Direction-aware service flag.
  function automatic logic service_flag(input logic       rd,
                                        input logic [5:0] lvl,
                                        input logic [5:0] depth,
                                        input logic [4:0] rd_thr,
                                        input logic [4:0] wr_thr);
    if (rd) return lvl >= {1'b0, rd_thr};
    return free_slots(lvl, depth) >= {1'b0, wr_thr};
  endfunction

  function automatic logic [31:0] pack_debug(input logic [FLD_W-1:0] lvl,
                                             input logic [FLD_W-1:0] wr_thr,
                                             input logic [FLD_W-1:0] rd_thr);
    logic [31:0] d;
    d = '0;
    d[DBG_LVL_LSB +: FLD_W] = lvl;
    d[DBG_WTH_LSB +: FLD_W] = wr_thr;
    d[DBG_RTH_LSB +: FLD_W] = rd_thr;
    return d;
  endfunction

  function automatic logic [31:0] pack_status(input logic flag, input logic err, input logic blk);
    logic [31:0] s;
    s = '0;
    s[ST_DATA_BIT] = flag;
    s[ST_ERR_BIT]  = err;
    s[ST_BLK_BIT]  = blk;
    return s;
  endfunction

endpackage

// File: rtl/sd_fifo_store.sv
module sd_fifo_store #(
  parameter  int DEPTH = 16,
  parameter  int WIDTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_req,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] head,
  output logic [LVL_W-1:0] level,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             ovf,
  output logic             udf
);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] cnt_q;
  logic [WIDTH-1:0] ent [DEPTH];
  logic             full, empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == LVL_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign ovf     = push_req && full;
  assign udf     = pop_req && empty;
  assign level   = cnt_q;
  assign head    = ent[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [WIDTH-1:0] word_q;
    always_ff @(posedge clk) begin
      if (push_ok && (wr_ptr == PTR_W'(i))) word_q <= push_data;
    end
    assign ent[i] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/sd_fifo_blkcnt.sv
module sd_fifo_blkcnt #(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             xfer_ok,
  input  logic [BLK_W-1:0] blk_words,
  output logic             blk_evt
);

  logic [BLK_W-1:0] cnt_q;
  logic             enabled, last;

  assign enabled = (blk_words != '0);
  assign last    = enabled && (cnt_q == blk_words - 1'b1);
  assign blk_evt = xfer_ok && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (flush)              cnt_q <= '0;
    else if (xfer_ok && enabled) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/sd_fifo_status.sv
module sd_fifo_status
  import sd_fifo_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_rd,
  input  logic [LVL_W-1:0] level,
  input  logic [FLD_W-1:0] rd_thr,
  input  logic [FLD_W-1:0] wr_thr,
  input  logic             err_evt,
  input  logic             clr_err,
  input  logic             blk_evt,
  input  logic             clr_blk,
  output logic             data_flag,
  output logic             err_q,
  output logic             blk_q
);

  assign data_flag = service_flag(dir_rd, 6'(level), 6'(DEPTH), rd_thr, wr_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      if (err_evt)      err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
      if (blk_evt)      blk_q <= 1'b1;
      else if (clr_blk) blk_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sd_data_fifo.sv
module sd_data_fifo
  import sd_fifo_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int WIDTH = 32,
  parameter  int BLK_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic             dir_rd,
  input  logic             host_wr_en,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             host_rd_en,
  output logic [WIDTH-1:0] host_rdata,
  input  logic             shf_push,
  input  logic [WIDTH-1:0] shf_push_data,
  input  logic             shf_pop,
  output logic [WIDTH-1:0] shf_pop_data,
  input  logic [4:0]       cfg_rd_thr,
  input  logic [4:0]       cfg_wr_thr,
  input  logic [BLK_W-1:0] cfg_blk_words,
  input  logic             cfg_data_irq_en,
  input  logic             cfg_blk_irq_en,
  input  logic             clr_err,
  input  logic             clr_blk,
  output logic [31:0]      dbg_word,
  output logic [31:0]      stat_word,
  output logic             irq
);

  // Named internal events, visible to the bound checker.
  logic             push_req, pop_req;
  logic [WIDTH-1:0] push_data, head;
  logic [LVL_W-1:0] level;
  logic             push_ok, pop_ok, ovf_evt, udf_evt;
  logic             xfer_ok, err_evt, blk_evt;
  logic             data_flag, err_q, blk_q;

  assign push_req  = !xfer_start && (dir_rd ? shf_push : host_wr_en);
  assign push_data = dir_rd ? shf_push_data : host_wdata;
  assign pop_req   = !xfer_start && (dir_rd ? host_rd_en : shf_pop);

  sd_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (xfer_start),
    .push_req (push_req),
    .push_data(push_data),
    .pop_req  (pop_req),
    .head     (head),
    .level    (level),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .ovf      (ovf_evt),
    .udf      (udf_evt)
  );

  assign xfer_ok = dir_rd ? push_ok : pop_ok;
  assign err_evt = ovf_evt | udf_evt;

  sd_fifo_blkcnt #(.BLK_W(BLK_W)) blkcnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (xfer_start),
    .xfer_ok  (xfer_ok),
    .blk_words(cfg_blk_words),
    .blk_evt  (blk_evt)
  );

  sd_fifo_status #(.DEPTH(DEPTH)) status_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_rd   (dir_rd),
    .level    (level),
    .rd_thr   (cfg_rd_thr),
    .wr_thr   (cfg_wr_thr),
    .err_evt  (err_evt),
    .clr_err  (clr_err),
    .blk_evt  (blk_evt),
    .clr_blk  (clr_blk),
    .data_flag(data_flag),
    .err_q    (err_q),
    .blk_q    (blk_q)
  );

  assign host_rdata   = (dir_rd && pop_ok)  ? head : '0;
  assign shf_pop_data = (!dir_rd && pop_ok) ? head : '0;
  assign dbg_word     = pack_debug(FLD_W'(level), cfg_wr_thr, cfg_rd_thr);
  assign stat_word    = pack_status(data_flag, err_q, blk_q);
  assign irq          = (data_flag & cfg_data_irq_en) | (blk_q & cfg_blk_irq_en);

endmodule

// File: rtl/sd_data_fifo_chk.sv
module sd_data_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] level,
  input logic             push_ok,
  input logic             pop_ok,
  input logic             ovf_evt,
  input logic             udf_evt,
  input logic             blk_evt,
  input logic             xfer_start,
  input logic             clr_err,
  input logic [WIDTH-1:0] host_rdata,
  input logic [WIDTH-1:0] shf_pop_data,
  input logic [31:0]      stat_word,
  input logic             irq,
  input logic             cfg_data_irq_en,
  input logic             cfg_blk_irq_en
);

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  // R1
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok && !xfer_start) |=> (level == LVL_W'($past(level) + 1'b1)));

  // R6
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> stat_word[3]);

  // R7
  udf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    udf_evt |-> (host_rdata == '0 && shf_pop_data == '0));

  // R8
  blk_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_evt |=> stat_word[9]);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !ovf_evt && !udf_evt) |=> !stat_word[3]);

  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> (level == '0));

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_data_irq_en && !cfg_blk_irq_en) |-> !irq);

endmodule

bind sd_data_fifo sd_data_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LVL_W(LVL_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .level          (level),
  .push_ok        (push_ok),
  .pop_ok         (pop_ok),
  .ovf_evt        (ovf_evt),
  .udf_evt        (udf_evt),
  .blk_evt        (blk_evt),
  .xfer_start     (xfer_start),
  .clr_err        (clr_err),
  .host_rdata     (host_rdata),
  .shf_pop_data   (shf_pop_data),
  .stat_word      (stat_word),
  .irq            (irq),
  .cfg_data_irq_en(cfg_data_irq_en),
  .cfg_blk_irq_en (cfg_blk_irq_en)
);

// File: tb/sd_data_fifo_tb_top.sv
`timescale 1ns/1ps
module sd_data_fifo_tb_top;

  localparam int NW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_start = 0, dir_rd = 1;
  logic        host_wr_en = 0, host_rd_en = 0, shf_push = 0, shf_pop = 0;
  logic [31:0] host_wdata = 0, shf_push_data = 0;
  logic [31:0] host_rdata, shf_pop_data, dbg_word, stat_word;
  logic [4:0]  cfg_rd_thr = 5'd4, cfg_wr_thr = 5'd4;
  logic [7:0]  cfg_blk_words = 8'd0;
  logic        cfg_data_irq_en = 0, cfg_blk_irq_en = 0, clr_err = 0, clr_blk = 0;
  logic        irq;

  always #2.5 clk = ~clk;

  sd_data_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .dir_rd(dir_rd),
    .host_wr_en(host_wr_en), .host_wdata(host_wdata), .host_rd_en(host_rd_en),
    .host_rdata(host_rdata), .shf_push(shf_push), .shf_push_data(shf_push_data),
    .shf_pop(shf_pop), .shf_pop_data(shf_pop_data), .cfg_rd_thr(cfg_rd_thr),
    .cfg_wr_thr(cfg_wr_thr), .cfg_blk_words(cfg_blk_words),
    .cfg_data_irq_en(cfg_data_irq_en), .cfg_blk_irq_en(cfg_blk_irq_en),
    .clr_err(clr_err), .clr_blk(clr_blk), .dbg_word(dbg_word),
    .stat_word(stat_word), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // Reference model state
  logic [31:0] q[$];
  bit          m_err = 0, m_blk = 0;
  int          m_cnt = 0;
  logic [31:0] last_rdata, last_pop;
  logic [31:0] rng = 32'h1234_5678;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // One clock: compare outputs against the model, then advance the model.
  task automatic step();
    int n; bit rd, flag, preq, qreq, pok, sok, ovf, udf, xf, bset;
    logic [31:0] e_rd, e_pop, e_dbg, e_st, pd;
    #1;
    n  = q.size();
    rd = dir_rd;
    e_rd  = (rd && host_rd_en && !xfer_start && n > 0) ? q[0] : 32'h0;
    e_pop = (!rd && shf_pop && !xfer_start && n > 0) ? q[0] : 32'h0;
    flag  = rd ? (n >= int'(cfg_rd_thr)) : ((NW - n) >= int'(cfg_wr_thr));
    e_dbg = (32'(cfg_rd_thr) << 14) | (32'(cfg_wr_thr) << 9) | (32'(n) << 4);
    e_st  = {22'b0, m_blk, 5'b0, m_err, 2'b0, flag};
    check("R1 host_rdata", host_rdata, e_rd);
    check("R1 shf_pop_data", shf_pop_data, e_pop);
    check("R2 dbg_word", dbg_word, e_dbg);
    check(rd ? "R3 stat_word" : "R4 stat_word", stat_word, e_st);
    check("R5 irq", 32'(irq), 32'((flag & cfg_data_irq_en) | (m_blk & cfg_blk_irq_en)));
    last_rdata = host_rdata;
    last_pop   = shf_pop_data;
    preq = !xfer_start && (rd ? shf_push : host_wr_en);
    pd   = rd ? shf_push_data : host_wdata;
    qreq = !xfer_start && (rd ? host_rd_en : shf_pop);
    pok  = qreq && n > 0;
    sok  = preq && n < NW;
    ovf  = preq && n == NW;
    udf  = qreq && n == 0;
    xf   = rd ? sok : pok;
    bset = 0;
    @(posedge clk);
    if (pok) void'(q.pop_front());
    if (sok) q.push_back(pd);
    if (xf && cfg_blk_words != 0) begin
      if (m_cnt == int'(cfg_blk_words) - 1) begin bset = 1; m_cnt = 0; end
      else m_cnt = (m_cnt + 1) & 255;
    end
    if (ovf || udf) m_err = 1; else if (clr_err) m_err = 0;
    if (bset) m_blk = 1; else if (clr_blk) m_blk = 0;
    if (xfer_start) begin q.delete(); m_cnt = 0; end
    @(negedge clk);
  endtask

  task automatic idle();
    xfer_start = 0; host_wr_en = 0; host_rd_en = 0; shf_push = 0; shf_pop = 0;
    clr_err = 0; clr_blk = 0;
  endtask

  task automatic spush(input logic [31:0] d);
    shf_push = 1; shf_push_data = d; step(); shf_push = 0;
  endtask
  task automatic hwrite(input logic [31:0] d);
    host_wr_en = 1; host_wdata = d; step(); host_wr_en = 0;
  endtask
  task automatic hread();
    host_rd_en = 1; step(); host_rd_en = 0;
  endtask
  task automatic spop();
    shf_pop = 1; step(); shf_pop = 0;
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 stat after reset", stat_word, 32'h0);
    check("R12 dbg after reset", dbg_word, 32'h0001_0800);
    rst_n = 1;
    @(negedge clk);

    // Read direction threshold, R3
    dir_rd = 1;
    for (int i = 0; i < 3; i++) spush(32'hA000_0000 + i);
    check("R3 flag below read threshold", 32'(stat_word[0]), 0);
    spush(32'hA000_0003);
    check("R3 flag at read threshold", 32'(stat_word[0]), 1);
    check("R2 level field", 32'(dbg_word[8:4]), 4);

    // Fill and overflow, R6
    for (int i = 4; i < 16; i++) spush(32'hA000_0000 + i);
    check("R2 level full", 32'(dbg_word[8:4]), 16);
    spush(32'hDEAD_BEEF);
    check("R6 overflow error", 32'(stat_word[3]), 1);
    check("R6 level unchanged", 32'(dbg_word[8:4]), 16);
    for (int i = 0; i < 16; i++) begin
      hread();
      check("R1 read order", last_rdata, 32'hA000_0000 + i);
    end
    hread();
    check("R7 empty read data", last_rdata, 0);
    check("R7 underflow error", 32'(stat_word[3]), 1);

    // Clear and collision, R9
    clr_err = 1; step(); clr_err = 0;
    check("R9 error cleared", 32'(stat_word[3]), 0);
    clr_err = 1; host_rd_en = 1; step(); idle();
    check("R9 set wins over clear", 32'(stat_word[3]), 1);
    clr_err = 1; step(); clr_err = 0;

    // Write direction threshold, R4
    dir_rd = 0;
    #1 check("R4 flag empty write", 32'(stat_word[0]), 1);
    for (int i = 0; i < 12; i++) hwrite(32'hB000_0000 + i);
    check("R4 flag four free", 32'(stat_word[0]), 1);
    hwrite(32'hB000_000C);
    check("R4 flag three free", 32'(stat_word[0]), 0);
    for (int i = 0; i < 13; i++) begin
      spop();
      check("R1 write order", last_pop, 32'hB000_0000 + i);
    end
    spop();
    check("R7 shifter underflow data", last_pop, 0);
    check("R7 shifter underflow error", 32'(stat_word[3]), 1);
    clr_err = 1; step(); clr_err = 0;

    // Wrong-side operations, R10
    spush(32'h1111_1111);
    check("R10 shifter push ignored in write dir", 32'(dbg_word[8:4]), 0);
    hwrite(32'h2222_2222);
    hread();
    check("R10 host read ignored in write dir", last_rdata, 0);
    check("R10 level after host read", 32'(dbg_word[8:4]), 1);
    dir_rd = 1;
    hwrite(32'h3333_3333);
    check("R10 host write ignored in read dir", 32'(dbg_word[8:4]), 1);
    spop();
    check("R10 shifter pop ignored in read dir", last_pop, 0);
    check("R10 no error from wrong side", 32'(stat_word[3]), 0);

    // Flush, R11
    xfer_start = 1; shf_push = 1; shf_push_data = 32'h4444_4444; step(); idle();
    check("R11 flush empties", 32'(dbg_word[8:4]), 0);
    check("R11 flush no error", 32'(stat_word[3]), 0);

    // Block completion and interrupts, R8 R5
    cfg_blk_words = 8'd4;
    for (int i = 0; i < 3; i++) spush(32'hC000_0000 + i);
    check("R8 block not yet", 32'(stat_word[9]), 0);
    spush(32'hC000_0003);
    check("R8 block complete", 32'(stat_word[9]), 1);
    check("R5 irq disabled", 32'(irq), 0);
    cfg_blk_irq_en = 1;
    #1 check("R5 irq from block", 32'(irq), 1);
    clr_blk = 1; step(); clr_blk = 0;
    check("R9 block cleared", 32'(stat_word[9]), 0);
    check("R5 irq after block clear", 32'(irq), 0);
    cfg_data_irq_en = 1;
    #1 check("R5 irq from data flag", 32'(irq), 1);
    cfg_data_irq_en = 0; cfg_blk_irq_en = 0; cfg_blk_words = 0;

    // Full with simultaneous push and pop, R6
    for (int i = 0; i < 12; i++) spush(32'hD000_0000 + i);
    shf_push = 1; shf_push_data = 32'hEEEE_EEEE; host_rd_en = 1; step(); idle();
    check("R6 push dropped at full", 32'(dbg_word[8:4]), 15);
    check("R6 error on simultaneous push", 32'(stat_word[3]), 1);
    xfer_start = 1; clr_err = 1; step(); idle();

    // Random mixed traffic against the model
    for (int c = 0; c < 4000; c++) begin
      rng = nxt(rng);
      shf_push = rng[0]; host_rd_en = rng[1]; host_wr_en = rng[2]; shf_pop = rng[3];
      shf_push_data = nxt(rng ^ 32'h5a5a_0000); host_wdata = ~shf_push_data;
      clr_err = (rng[7:4] == 0); clr_blk = (rng[11:8] == 0);
      xfer_start = (rng[19:12] == 0);
      if (rng[27:20] == 0) dir_rd = ~dir_rd;
      if (rng[31:24] == 8'h11) begin cfg_rd_thr = rng[16:12]; cfg_wr_thr = rng[21:17]; end
      if (xfer_start) cfg_blk_words = {5'b0, rng[30:28]};
      cfg_data_irq_en = rng[22]; cfg_blk_irq_en = rng[23];
      step();
    end
    idle();
    step();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule